// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block takes one input clock and produces two divided clocks from two counters that step together on the same rising input edge. Bank A divides by 2 or 4. Bank B divides by 4, 5 or 6. Static select pins choose each ratio, so the two outputs keep fixed phase relationships and their shared edges fall on the same input edge.

A halt request freezes both banks. The request is captured on the falling input edge, so both dividers start and stop only between clock pulses, and no pulse is ever cut short. An asynchronous master reset clears every counter and drives both outputs low. Several instances released from the same reset therefore stay in phase with each other. A build parameter can stretch the divide-by-5 high phase by half an input cycle to give a 50% duty cycle. It is off by default, and the requirements below assume the default.

Top module: `ratioClockDivider`

## Requirements
- R1: Bank A ratio is set by `selA`: 0 selects divide by 2 and 1 selects divide by 4.
- R2: Bank B ratio is set by {`selB1`,`selB0`}: 00 selects divide by 4, 01 selects divide by 6, and 10 or 11 select divide by 5.
- R3: With divide by 2, 4 or 6, high time equals low time, each half the period. With divide by 5, the output is high for 2 input cycles and low for 3.
- R4: While the captured halt request is 1, both outputs and both counters keep their values across rising input edges. While it is 0, each bank moves one step per rising input edge.
- R5: `haltReq` is sampled only on falling `clkIn` edges. A pulse that rises after one falling edge and ends before the next falling edge has no effect, even if it spans a rising edge.
- R6: While `masterRst` is 1, both outputs are 0. The reset acts at once, without waiting for a clock edge, and holds whatever `clkIn` and `haltReq` do.
- R7: Count the rising input edges after `masterRst` falls, starting at 1. For a bank dividing by r, the first rising output edge comes on edge ceil(r/2): edge 1 for ÷2, edge 2 for ÷4, and edge 3 for ÷5 and ÷6. Both outputs are low until then.
- R8: With both banks at divide by 4, the two outputs are identical on every cycle. With bank A at divide by 2 and bank B at 4 or 6, every falling edge of `outB` coincides with a falling edge of `outA`.
- R9: A select change is picked up when that bank's count is back at zero. The period already in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock to be divided |
| masterRst | input | 1 | Asynchronous active-high reset of all divider state |
| haltReq | input | 1 | 1 freezes both banks, sampled on falling clkIn edges |
| selA | input | 1 | Bank A ratio select |
| selB0 | input | 1 | Bank B ratio select, low bit |
| selB1 | input | 1 | Bank B ratio select, high bit (1 forces divide by 5) |
| outA | output | 1 | Bank A divided clock |
| outB | output | 1 | Bank B divided clock |

## Verification
Three events can meet in one input cycle: a halt request that changes, a select change, and a counter wrap. Meanwhile reset can arrive at any moment. The bench provokes these overlaps in two ways. It issues random halt toggles and select changes in the middle of a period, and it adds directed cases: a halt pulse that spans a rising edge but misses both falling edges, and a reset raised halfway through a low phase. Every cycle's outputs are compared with a bench model that samples the halt at falling edges and picks up a new ratio only at count zero. Reset is judged a few nanoseconds after it is raised, without waiting for any edge.

// File: rtl/divPkg.sv
package divPkg;

  // largest divide ratio the counters must reach
  localparam int MAX_RATIO = 6;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  typedef logic [CNT_W-1:0] ratio_t;

  localparam ratio_t RATIO_TWO  = ratio_t'(2);
  localparam ratio_t RATIO_FOUR = ratio_t'(4);
  localparam ratio_t RATIO_FIVE = ratio_t'(5);
  localparam ratio_t RATIO_SIX  = ratio_t'(6);

  // strobes from control to the divider banks
  typedef struct packed {
    logic advance;   // step the counters on this rising edge
  } ctlStrobe_t;

  function automatic ratio_t decodeA(input logic sel);
    return sel ? RATIO_FOUR : RATIO_TWO;
  endfunction

  function automatic ratio_t decodeB(input logic hiBit, input logic loBit);
    if (hiBit) return RATIO_FIVE;
    return loBit ? RATIO_SIX : RATIO_FOUR;
  endfunction

  // number of counter states with the output low: ceil(r/2)
  function automatic ratio_t lowSpan(input ratio_t r);
    logic [CNT_W:0] wide;
    wide = {1'b0, r} + 1'b1;
    return ratio_t'(wide >> 1);
  endfunction

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
(
  input  logic       clkIn,
  input  logic       masterRst,
  input  logic       haltReq,
  input  logic       selA,
  input  logic       selB0,
  input  logic       selB1,
  output ctlStrobe_t ctlBus,
  output ratio_t     ratioA,
  output ratio_t     ratioB
);

  logic haltQ;

  // captured between pulses so gating never clips a high phase
  always_ff @(negedge clkIn or posedge masterRst) begin
    if (masterRst) haltQ <= 1'b0;
    else           haltQ <= haltReq;
  end

  assign ctlBus.advance = !haltQ;
  assign ratioA         = decodeA(selA);
  assign ratioB         = decodeB(selB1, selB0);

endmodule

// File: rtl/divBank.sv
module divBank
  import divPkg::*;
#(
  parameter bit ODD_STRETCH = 1'b0
) (
  input  logic       clkIn,
  input  logic       masterRst,
  input  ctlStrobe_t ctlBus,
  input  ratio_t     ratioSel,
  output logic       divOut
);

  ratio_t count;
  ratio_t countNext;
  ratio_t heldRatio;
  ratio_t effRatio;
  logic   outQ;
  logic   outNext;

  // a new ratio is only picked up at the start of a period
  assign effRatio = (count == '0) ? ratioSel : heldRatio;

  always_comb begin
    if (count == ratio_t'(effRatio - 1'b1)) countNext = '0;
    else                                    countNext = count + 1'b1;
    outNext = (countNext >= lowSpan(effRatio));
  end

  always_ff @(posedge clkIn or posedge masterRst) begin
    if (masterRst) begin
      count     <= '0;
      heldRatio <= RATIO_FOUR;
      outQ      <= 1'b0;
    end else if (ctlBus.advance) begin
      count <= countNext;
      outQ  <= outNext;
      if (count == '0) heldRatio <= ratioSel;
    end
  end

  generate
    if (ODD_STRETCH) begin : gStretch
      logic lateQ;
      always_ff @(negedge clkIn or posedge masterRst) begin
        if (masterRst) lateQ <= 1'b0;
        else           lateQ <= outQ;
      end
      // odd ratios keep the output high half a cycle longer
      assign divOut = outQ | (lateQ & heldRatio[0]);
    end else begin : gPlain
      assign divOut = outQ;
    end
  endgenerate

endmodule

// File: rtl/ratioClockDivider.sv
module ratioClockDivider
  import divPkg::*;
#(
  parameter bit STRETCH_ODD = 1'b0
) (
  input  logic clkIn,
  input  logic masterRst,
  input  logic haltReq,
  input  logic selA,
  input  logic selB0,
  input  logic selB1,
  output logic outA,
  output logic outB
);

  ctlStrobe_t ctlBus;
  ratio_t     ratioA;
  ratio_t     ratioB;

  divCtrl uCtrl (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .haltReq   (haltReq),
    .selA      (selA),
    .selB0     (selB0),
    .selB1     (selB1),
    .ctlBus    (ctlBus),
    .ratioA    (ratioA),
    .ratioB    (ratioB)
  );

  // bank A never runs an odd ratio, so it never needs the stretch
  divBank #(.ODD_STRETCH(1'b0)) uBankA (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .ctlBus    (ctlBus),
    .ratioSel  (ratioA),
    .divOut    (outA)
  );

  divBank #(.ODD_STRETCH(STRETCH_ODD)) uBankB (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .ctlBus    (ctlBus),
    .ratioSel  (ratioB),
    .divOut    (outB)
  );

endmodule

// File: rtl/ratioClockDivider_chk.sv
module ratioClockDivider_chk (
  input logic clkIn,
  input logic masterRst,
  input logic advance,
  input logic outA,
  input logic outB
);

  logic [3:0] hiRunA;
  logic [3:0] hiRunB;

  // advancing edges seen while each output is high
  always_ff @(posedge clkIn or posedge masterRst) begin
    if (masterRst) begin
      hiRunA <= '0;
      hiRunB <= '0;
    end else begin
      if (!outA)                          hiRunA <= '0;
      else if (advance && hiRunA != 4'hF) hiRunA <= hiRunA + 1'b1;
      if (!outB)                          hiRunB <= '0;
      else if (advance && hiRunB != 4'hF) hiRunB <= hiRunB + 1'b1;
    end
  end

  assert_reset_low_R6: assert property (
    @(negedge clkIn) masterRst |-> (!outA && !outB));

  assert_halt_freeze_R4: assert property (
    @(posedge clkIn) disable iff (masterRst)
    !advance |=> ($stable(outA) && $stable(outB)));

  assert_high_span_a_R3: assert property (
    @(posedge clkIn) disable iff (masterRst) hiRunA <= 4'd2);

  assert_high_span_b_R3: assert property (
    @(posedge clkIn) disable iff (masterRst) hiRunB <= 4'd3);

endmodule

bind ratioClockDivider ratioClockDivider_chk uChk (
  .clkIn     (clkIn),
  .masterRst (masterRst),
  .advance   (ctlBus.advance),
  .outA      (outA),
  .outB      (outB)
);

// File: tb/ratioClockDivider_test.sv
module ratioClockDivider_test;

  logic clkIn = 1'b0;
  logic masterRst, haltReq, selA, selB0, selB1;
  logic outA, outB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  int mCntA, mCntB, mHeldA, mHeldB;
  bit mRun, mOutA, mOutB;
  logic [63:0] trA, trB;

  ratioClockDivider uut (
    .clkIn(clkIn), .masterRst(masterRst), .haltReq(haltReq),
    .selA(selA), .selB0(selB0), .selB1(selB1),
    .outA(outA), .outB(outB)
  );

  always #10 clkIn = ~clkIn;   // 50 MHz

  function automatic int ratioOfA(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int ratioOfB(input logic b1, input logic b0);
    if (b1) return 5;
    return b0 ? 6 : 4;
  endfunction

  task automatic checkBit(input string req, input string what,
                          input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string req, input string what,
                          input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic advModel(inout int cnt, inout int held, input int sel, output bit o);
    int eff;
    eff = (cnt == 0) ? sel : held;
    if (cnt == 0) held = sel;
    cnt = (cnt == eff - 1) ? 0 : cnt + 1;
    o = (cnt >= (eff + 1) / 2);
  endtask

  task automatic modelClear();
    mCntA = 0; mCntB = 0; mHeldA = 4; mHeldB = 4;
    mOutA = 0; mOutB = 0; mRun = 1;
  endtask

  task automatic modelEdge();
    if (!masterRst && mRun) begin
      advModel(mCntA, mHeldA, ratioOfA(selA), mOutA);
      advModel(mCntB, mHeldB, ratioOfB(selB1, selB0), mOutB);
    end
    if (masterRst) begin mOutA = 0; mOutB = 0; end
  endtask

  // one input cycle; returns at posedge + 5 ns
  task automatic step(input string req);
    @(negedge clkIn);
    if (!masterRst) mRun = !haltReq;
    @(posedge clkIn); #5;
    modelEdge();
    checkBit(req, "outA", outA, mOutA);
    checkBit(req, "outB", outB, mOutB);
  endtask

  task automatic doReset();
    masterRst = 1'b1;
    #1;
    checkBit("R6", "outA immediate", outA, 1'b0);
    checkBit("R6", "outB immediate", outB, 1'b0);
    modelClear();
    haltReq = 1'b1;
    step("R6");
    haltReq = 1'b0;
    step("R6");
    masterRst = 1'b0;
  endtask

  task automatic runTrace(input int n, input string req);
    trA = '0; trB = '0;
    for (int i = 0; i < n; i++) begin
      step(req);
      trA[i] = outA;
      trB[i] = outB;
    end
  endtask

  task automatic analyze(input logic [63:0] tr, input int n,
                         output int firstRise, output int period, output int highLen);
    int r1, r2;
    r1 = -1; r2 = -1; highLen = 0;
    for (int i = 0; i < n; i++) begin
      if (tr[i] && (i == 0 || !tr[i-1])) begin
        if (r1 < 0) r1 = i;
        else if (r2 < 0) r2 = i;
      end
    end
    firstRise = r1 + 1;
    period = r2 - r1;
    for (int j = 0; j < n; j++)
      if (j >= r1 && j < r2 && tr[j]) highLen++;
  endtask

  task automatic ratioCase(input logic a, input logic b1, input logic b0);
    int f, p, h, ra, rb;
    selA = a; selB1 = b1; selB0 = b0;
    doReset();
    runTrace(30, "R7");
    ra = ratioOfA(a); rb = ratioOfB(b1, b0);
    analyze(trA, 30, f, p, h);
    checkInt("R7", "A first rise", f, (ra + 1) / 2);
    checkInt("R1", "A period", p, ra);
    checkInt("R3", "A high time", h, ra - (ra + 1) / 2);
    analyze(trB, 30, f, p, h);
    checkInt("R7", "B first rise", f, (rb + 1) / 2);
    checkInt("R2", "B period", p, rb);
    checkInt("R3", "B high time", h, rb - (rb + 1) / 2);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    masterRst = 1'b1; haltReq = 1'b0; selA = 1'b0; selB0 = 1'b0; selB1 = 1'b0;
    modelClear();
    @(posedge clkIn); #5;
    checkBit("R6", "reset outA", outA, 1'b0);
    checkBit("R6", "reset outB", outB, 1'b0);
    masterRst = 1'b0;

    // R1 R2 R3 R7: every select combination
    for (int k = 0; k < 8; k++) ratioCase(k[2], k[1], k[0]);

    // R8: both at divide by 4 give identical outputs
    selA = 1; selB1 = 0; selB0 = 0;
    doReset();
    runTrace(24, "R8");
    for (int i = 0; i < 24; i++) checkBit("R8", "A4 equals B4", trA[i], trB[i]);

    // R8: B falling edges coincide with A falling edges (A at 2)
    for (int v = 0; v < 2; v++) begin
      selA = 0; selB1 = 0; selB0 = v[0];
      doReset();
      runTrace(36, "R8");
      for (int i = 1; i < 36; i++)
        if (trB[i-1] && !trB[i]) checkBit("R8", "A falls with B", trA[i-1] & !trA[i], 1'b1);
    end

    // R9: ratio change in the middle of a period
    selA = 1; selB1 = 0; selB0 = 0;
    doReset();
    step("R9");
    selA = 0; selB0 = 1;
    for (int i = 0; i < 14; i++) step("R9");

    // R4: halt freezes outputs
    haltReq = 1;
    step("R4");
    for (int i = 0; i < 6; i++) begin
      logic pa, pb;
      pa = outA; pb = outB;
      step("R4");
      checkBit("R4", "outA frozen", outA, pa);
      checkBit("R4", "outB frozen", outB, pb);
    end
    haltReq = 0;
    for (int i = 0; i < 6; i++) step("R4");

    // R5: a pulse spanning a rising edge but no falling edge is ignored
    for (int g = 0; g < 3; g++) begin
      logic pa;
      pa = outA;
      @(negedge clkIn);
      mRun = !haltReq;
      #2 haltReq = 1;
      @(posedge clkIn);
      #2 haltReq = 0;
      #3;
      modelEdge();
      checkBit("R5", "outA moved past pulse", outA, !pa);
      checkBit("R5", "outB", outB, mOutB);
    end

    // R6: reset raised half way through the low phase
    @(negedge clkIn);
    #3 masterRst = 1;
    #1;
    checkBit("R6", "outA async", outA, 1'b0);
    checkBit("R6", "outB async", outB, 1'b0);
    modelClear();
    step("R6");
    masterRst = 0;
    for (int i = 0; i < 8; i++) step("R7");

    // random mix of halts, select changes, pulses and resets
    for (int it = 0; it < 600; it++) begin
      int roll;
      roll = $urandom_range(0, 99);
      if (roll < 3) doReset();
      else if (roll < 15) haltReq = 1'($urandom_range(0, 1));
      else if (roll < 22) begin
        selA = 1'($urandom_range(0, 1));
        selB0 = 1'($urandom_range(0, 1));
        selB1 = 1'($urandom_range(0, 1));
      end
      step("R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule